// File: doc/BRIEF.md
# Multi-Trace Statistics Accumulator

This block keeps a sliding history of the last K acquired traces and turns it into one display value per time bin. Samples arrive one at a time with a bin index. They are collected in a staging buffer until an end-of-trace strobe. The strobe starts a commit walk that visits each bin once. For each bin the walk makes one read-modify-write: it adds the new sample to the bin's running sum and subtracts the sample of the trace being evicted. It also writes the new sample into the history slot and rescans the stored slots of that bin to refresh its minimum and maximum.

A display reader presents a bin index and a view mode. One cycle later the block returns the most recent trace's value, the sliding mean over the stored traces, or the peak pair (minimum and maximum). The mean is a true FIR mean over the window. It divides by the number of traces actually held until the window is full, and after that it is a right shift. The same path serves any acquisition scheme that delivers aligned traces, whether continuous or triggered. A clear input empties the window at any time.

Top module: `mts_accum`

## Requirements
- R1: After reset or a clear, no trace is held: `not_full` is 1, `busy` is 0, and every view returns 0 on both display outputs.
- R2: A sample with `smp_vld` high, while `busy` and `clr` are low, is stored for bin `smp_bin` of the trace being collected. A later sample to the same bin of the same trace replaces it. A bin that gets no sample in a trace counts as 0.
- R3: `eot` high while `busy` and `clr` are low closes the trace. A sample presented in that same cycle belongs to the closed trace. `busy` is then 1 for exactly NBINS cycles, starting at the next clock edge, and after that the trace is part of the window.
- R4: Samples and `eot` presented while `busy` is 1 have no effect on the stored traces or on the next trace.
- R5: View mode 0 (and mode 3) returns the newest committed trace's sample for `rd_bin` on both `disp_val` and `disp_min`.
- R6: View mode 1 returns floor(sum of the bin over the held traces / number held) on both outputs. The window holds at most K traces, and committing a trace to a full window drops the oldest one.
- R7: View mode 2 returns the per-bin maximum over the held traces on `disp_val` and the minimum on `disp_min`.
- R8: `not_full` is 1 while fewer than K traces are held and 0 once K are held.
- R9: `clr` wins over `eot` and `smp_vld` in the same cycle: those inputs are dropped. A clear during a commit abandons that trace, and `busy` is 0 at the next edge.
- R10: The display outputs are registered. They reflect `rd_bin`, `mode` and the held traces as they stood at the previous clock edge, and they are 0 while no trace is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty the trace window |
| smp_vld | input | 1 | Sample strobe |
| smp_bin | input | $clog2(NBINS) | Bin of the sample |
| smp_dat | input | DW | Sample value (unsigned) |
| eot | input | 1 | End of the trace being collected |
| mode | input | 2 | View: 0 latest, 1 mean, 2 peak, 3 latest |
| rd_bin | input | $clog2(NBINS) | Bin to display |
| disp_val | output | DW | Latest, mean or maximum |
| disp_min | output | DW | Minimum in peak view, else equal to disp_val |
| busy | output | 1 | Commit walk in progress |
| not_full | output | 1 | Fewer than K traces held |

## Verification
Two collisions matter. One is the last sample of a trace arriving in the same cycle as its end-of-trace strobe. The other is a clear landing together with an end-of-trace, or in the middle of a commit walk. The bench provokes the first on every full trace. It provokes the second once with clear and strobe in the same cycle, and once with clear a few cycles into a walk. A behavioural model holds the traces in a queue and treats the commit as one atomic step at its last cycle. Every cycle it judges `busy`, `not_full` and, whenever no walk was running at the sampling edge, both display outputs across sweeps of all bins and modes.

// File: rtl/mts_pkg.sv
package mts_pkg;
   typedef enum logic [1:0] {
      VIEW_LAST = 2'd0,
      VIEW_MEAN = 2'd1,
      VIEW_PEAK = 2'd2,
      VIEW_ALT  = 2'd3
   } view_e;
endpackage

// File: rtl/mts_ctrl.sv
module mts_ctrl #(
   parameter int NBINS = 16,
   parameter int K     = 8,
   localparam int BW   = $clog2(NBINS),
   localparam int PW   = $clog2(K),
   localparam int CW   = $clog2(K + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          eot,
   output logic          busy,
   output logic [BW-1:0] idx,
   output logic [PW-1:0] wr,
   output logic [CW-1:0] cnt
);
   localparam logic [BW-1:0] LAST = BW'(NBINS - 1);
   localparam logic [CW-1:0] CAP  = CW'(K);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         wr   <= '0;
         cnt  <= '0;
      end else if (clr) begin
         busy <= 1'b0;
         idx  <= '0;
         wr   <= '0;
         cnt  <= '0;
      end else if (busy) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
            wr   <= wr + 1'b1;
            if (cnt != CAP) cnt <= cnt + 1'b1;
         end else begin
            idx <= idx + 1'b1;
         end
      end else if (eot) begin
         busy <= 1'b1;
         idx  <= '0;
      end
   end

   // R3
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eot && !busy && !clr) |=> (busy && idx == '0));
   // R3
   walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == LAST && !clr) |=> (!busy && wr == $past(wr) + 1'b1));
   // R4
   walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST && !clr) |=> busy);
   // R9
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!busy && cnt == '0));
   // R8
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAP);
endmodule

// File: rtl/mts_store.sv
module mts_store #(
   parameter int NBINS = 16,
   parameter int K     = 8,
   parameter int DW    = 8,
   localparam int BW   = $clog2(NBINS),
   localparam int PW   = $clog2(K),
   localparam int CW   = $clog2(K + 1),
   localparam int SW   = DW + PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_we,
   input  logic [BW-1:0] smp_bin,
   input  logic [DW-1:0] smp_dat,
   input  logic          busy,
   input  logic [BW-1:0] idx,
   input  logic [PW-1:0] wr,
   input  logic [CW-1:0] cnt,
   input  logic [BW-1:0] rd_bin,
   output logic [DW-1:0] rd_last,
   output logic [SW-1:0] rd_sum,
   output logic [DW-1:0] rd_min,
   output logic [DW-1:0] rd_max
);
   logic [DW-1:0] hist_q [K][NBINS];
   logic [DW-1:0] stage_w [NBINS];
   logic [SW-1:0] sum_w [NBINS];
   logic [DW-1:0] mn_w [NBINS];
   logic [DW-1:0] mx_w [NBINS];

   logic          full;
   logic [DW-1:0] cur, old, lo, hi;
   logic [SW-1:0] sum_nx;

   assign full = (cnt == CW'(K));
   assign cur  = stage_w[idx];
   assign old  = hist_q[wr][idx];
   assign sum_nx = sum_w[idx] + SW'(cur) - (full ? SW'(old) : '0);

   // scan the bin's surviving slots plus the incoming sample
   always_comb begin
      lo = cur;
      hi = cur;
      for (int s = 0; s < K; s++) begin
         if (PW'(s) != wr && (full || PW'(s) < wr)) begin
            if (hist_q[s][idx] < lo) lo = hist_q[s][idx];
            if (hist_q[s][idx] > hi) hi = hist_q[s][idx];
         end
      end
   end

   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      logic [DW-1:0] stg_q, mn_q, mx_q;
      logic [SW-1:0] sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q <= '0; sum_q <= '0; mn_q <= '0; mx_q <= '0;
         end else if (clr) begin
            stg_q <= '0; sum_q <= '0; mn_q <= '0; mx_q <= '0;
         end else if (busy && idx == BW'(b)) begin
            stg_q <= '0;
            sum_q <= sum_nx;
            mn_q  <= lo;
            mx_q  <= hi;
         end else if (smp_we && smp_bin == BW'(b)) begin
            stg_q <= smp_dat;
         end
      end
      assign stage_w[b] = stg_q;
      assign sum_w[b]   = sum_q;
      assign mn_w[b]    = mn_q;
      assign mx_w[b]    = mx_q;
   end

   always_ff @(posedge clk) begin
      if (busy && !clr) hist_q[wr][idx] <= cur;
   end

   logic          rd_ok;
   logic [BW-1:0] rd_ix;
   logic [PW-1:0] newest;
   assign rd_ok   = int'(rd_bin) < NBINS;
   assign rd_ix   = rd_ok ? rd_bin : '0;
   assign newest  = wr - 1'b1;
   assign rd_last = rd_ok ? hist_q[newest][rd_ix] : '0;
   assign rd_sum  = rd_ok ? sum_w[rd_ix] : '0;
   assign rd_min  = rd_ok ? mn_w[rd_ix] : '0;
   assign rd_max  = rd_ok ? mx_w[rd_ix] : '0;

   // R7
   peak_order_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_min <= rd_max);
endmodule

// File: rtl/mts_view.sv
module mts_view
   import mts_pkg::*;
#(
   parameter int K     = 8,
   parameter int DW    = 8,
   localparam int PW   = $clog2(K),
   localparam int CW   = $clog2(K + 1),
   localparam int SW   = DW + PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] cnt,
   input  logic [DW-1:0] rd_last,
   input  logic [SW-1:0] rd_sum,
   input  logic [DW-1:0] rd_min,
   input  logic [DW-1:0] rd_max,
   output logic [DW-1:0] disp_val,
   output logic [DW-1:0] disp_min
);
   logic [SW-1:0] quot;
   logic [DW-1:0] nx_val, nx_min;
   view_e         vm;

   assign vm = view_e'(mode);

   always_comb begin
      if (cnt == CW'(K))      quot = rd_sum >> PW;
      else if (cnt != '0)     quot = rd_sum / SW'(cnt);
      else                    quot = '0;
   end

   always_comb begin
      nx_val = rd_last;
      nx_min = rd_last;
      if (cnt == '0) begin
         nx_val = '0;
         nx_min = '0;
      end else if (vm == VIEW_MEAN) begin
         nx_val = DW'(quot);
         nx_min = DW'(quot);
      end else if (vm == VIEW_PEAK) begin
         nx_val = rd_max;
         nx_min = rd_min;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_val <= '0;
         disp_min <= '0;
      end else begin
         disp_val <= nx_val;
         disp_min <= nx_min;
      end
   end

   // R7
   peak_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'd2) |-> (disp_min <= disp_val));
   // R5
   last_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'd0) |-> (disp_min == disp_val));
   // R10
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) == '0) |-> (disp_val == '0 && disp_min == '0));
endmodule

// File: rtl/mts_accum.sv
module mts_accum #(
   parameter int NBINS = 16,
   parameter int K     = 8,
   parameter int DW    = 8,
   localparam int BW   = $clog2(NBINS),
   localparam int PW   = $clog2(K),
   localparam int CW   = $clog2(K + 1),
   localparam int SW   = DW + PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp_vld,
   input  logic [BW-1:0] smp_bin,
   input  logic [DW-1:0] smp_dat,
   input  logic          eot,
   input  logic [1:0]    mode,
   input  logic [BW-1:0] rd_bin,
   output logic [DW-1:0] disp_val,
   output logic [DW-1:0] disp_min,
   output logic          busy,
   output logic          not_full
);
   if (K < 2 || K > 16 || (K & (K - 1)) != 0) begin : g_bad_k
      $error("mts_accum: K must be a power of two from 2 to 16");
   end
   if (NBINS < 2) begin : g_bad_bins
      $error("mts_accum: NBINS must be at least 2");
   end
   if (DW < 1 || DW > 24) begin : g_bad_dw
      $error("mts_accum: DW out of range");
   end

   logic [BW-1:0] idx;
   logic [PW-1:0] wr;
   logic [CW-1:0] cnt;
   logic          smp_we;
   logic [DW-1:0] rd_last, rd_min, rd_max;
   logic [SW-1:0] rd_sum;

   assign smp_we   = smp_vld && !busy && !clr;
   assign not_full = cnt < CW'(K);

   mts_ctrl #(.NBINS(NBINS), .K(K)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clr(clr), .eot(eot),
      .busy(busy), .idx(idx), .wr(wr), .cnt(cnt)
   );

   mts_store #(.NBINS(NBINS), .K(K), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .smp_we(smp_we), .smp_bin(smp_bin), .smp_dat(smp_dat),
      .busy(busy), .idx(idx), .wr(wr), .cnt(cnt), .rd_bin(rd_bin),
      .rd_last(rd_last), .rd_sum(rd_sum), .rd_min(rd_min), .rd_max(rd_max)
   );

   mts_view #(.K(K), .DW(DW)) u_view (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cnt(cnt),
      .rd_last(rd_last), .rd_sum(rd_sum), .rd_min(rd_min), .rd_max(rd_max),
      .disp_val(disp_val), .disp_min(disp_min)
   );

   // R1
   empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> not_full);
endmodule

// File: tb/mts_accum_tb.sv
`timescale 1ns/1ps
module mts_accum_tb;
   localparam int NB = 16;
   localparam int KD = 8;
   localparam int DW = 8;
   localparam int BW = $clog2(NB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, smp_vld = 1'b0, eot = 1'b0;
   logic [BW-1:0] smp_bin = '0, rd_bin = '0;
   logic [DW-1:0] smp_dat = '0;
   logic [1:0] mode = 2'd0;
   logic [DW-1:0] disp_val, disp_min;
   logic busy, not_full;

   always #2.5 clk = ~clk;

   mts_accum #(.NBINS(NB), .K(KD), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
      .smp_bin(smp_bin), .smp_dat(smp_dat), .eot(eot), .mode(mode),
      .rd_bin(rd_bin), .disp_val(disp_val), .disp_min(disp_min),
      .busy(busy), .not_full(not_full)
   );

   int n_cmp = 0, n_bad = 0;
   string phase = "R1";

   // behavioural model: queue of whole traces, atomic commit
   int fl[$];
   int stg[NB];
   int mbusy = 0;
   bit mvalid = 0, chk_disp = 0;
   int ev = 0, em = 0, eb = 0, enf = 1;
   string dtag = "R1";

   always @(posedge clk) begin
      int cnt, s, lo, hi, b;
      if (!rst_n) begin
         fl.delete();
         foreach (stg[i]) stg[i] = 0;
         mbusy = 0; mvalid = 0;
      end else begin
         cnt = fl.size() / NB;
         b = int'(rd_bin);
         chk_disp = (mbusy == 0);
         if (cnt == 0) begin
            ev = 0; em = 0; dtag = "R10";
         end else if (mode == 2'd1) begin
            s = 0;
            for (int t = 0; t < cnt; t++) s += fl[t*NB + b];
            ev = s / cnt; em = ev; dtag = "R6";
         end else if (mode == 2'd2) begin
            lo = 1 << DW; hi = -1;
            for (int t = 0; t < cnt; t++) begin
               if (fl[t*NB + b] < lo) lo = fl[t*NB + b];
               if (fl[t*NB + b] > hi) hi = fl[t*NB + b];
            end
            ev = hi; em = lo; dtag = "R7";
         end else begin
            ev = fl[(cnt-1)*NB + b]; em = ev; dtag = "R5";
         end
         if (clr) begin
            fl.delete();
            foreach (stg[i]) stg[i] = 0;
            mbusy = 0;
         end else if (mbusy > 0) begin
            mbusy--;
            if (mbusy == 0) begin
               for (int i = 0; i < NB; i++) fl.push_back(stg[i]);
               if (fl.size() > KD*NB) for (int i = 0; i < NB; i++) void'(fl.pop_front());
               foreach (stg[i]) stg[i] = 0;
            end
         end else begin
            if (smp_vld) stg[int'(smp_bin)] = int'(smp_dat);
            if (eot) mbusy = NB;
         end
         eb = (mbusy != 0);
         enf = (fl.size() / NB) < KD;
         mvalid = 1;
      end
   end

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && mvalid) begin
         check("R3 busy", int'(busy), eb);
         check("R8 not_full", int'(not_full), enf);
         if (chk_disp) begin
            check({dtag, " disp_val"}, int'(disp_val), ev);
            check({dtag, " disp_min"}, int'(disp_min), em);
         end
      end
   end

   function automatic int pat(int kind, int b);
      case (kind)
         0: return 255;
         1: return 0;
         2: return b * 16;
         default: return (kind * 37 + b * 91 + 13) % 256;
      endcase
   endfunction

   // full trace; last sample shares its cycle with eot (R3)
   task automatic send_trace(int kind, bit clr_last);
      for (int b = 0; b < NB; b++) begin
         smp_vld = 1; smp_bin = BW'(b); smp_dat = DW'(pat(kind, b));
         eot = (b == NB - 1);
         clr = clr_last && (b == NB - 1);
         @(negedge clk);
      end
      smp_vld = 0; eot = 0; clr = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sweep();
      for (int m = 0; m < 4; m++)
         for (int b = 0; b < NB; b++) begin
            mode = 2'(m); rd_bin = BW'(b);
            @(negedge clk);
         end
   endtask

   bit done = 0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      phase = "R1"; sweep();                    // R1, R10: empty window
      phase = "R2"; send_trace(3, 0); idle(NB + 2); sweep();
      // R2: partial trace, bin 2 written twice, others stay 0
      for (int b = 0; b < 5; b++) begin
         smp_vld = 1; smp_bin = BW'(b); smp_dat = DW'(40 + b); @(negedge clk);
      end
      smp_bin = 2; smp_dat = 200; eot = 1; @(negedge clk);
      smp_vld = 0; eot = 0;
      idle(NB + 2); sweep();
      // R6, R8: fill and overflow the window with extreme and varied values
      phase = "R6";
      for (int t = 0; t < KD; t++) begin
         send_trace((t % 2 == 0) ? 0 : 4 + t, 0); idle(NB + 2);
         if (t == 2 || t == KD - 1) sweep();
      end
      for (int t = 0; t < KD; t++) begin send_trace(0, 0); idle(NB + 2); end
      sweep();                                   // full window of 255s
      send_trace(1, 0); idle(NB + 2); send_trace(2, 0); idle(NB + 2); sweep();
      // R4: junk during a commit must not reach the window or the next trace
      phase = "R4";
      send_trace(9, 0);
      for (int i = 0; i < NB - 2; i++) begin
         smp_vld = 1; smp_bin = BW'(i); smp_dat = 8'hA5; eot = (i == 3);
         @(negedge clk);
      end
      smp_vld = 0; eot = 0; idle(4);
      smp_vld = 1; smp_bin = 0; smp_dat = 7; eot = 1; @(negedge clk);
      smp_vld = 0; eot = 0; idle(NB + 2); sweep();
      // R9: clear together with eot and the last sample
      phase = "R9";
      send_trace(5, 1); idle(NB + 2); sweep();
      send_trace(6, 0); idle(NB + 2);
      send_trace(7, 0); idle(5);
      clr = 1; smp_vld = 1; smp_bin = 1; smp_dat = 99; @(negedge clk);
      clr = 0; smp_vld = 0; idle(NB + 2); sweep();
      // R5, R7: window refilled after the clear
      phase = "R7";
      send_trace(11, 0); idle(NB + 2); send_trace(2, 0); idle(NB + 2);
      send_trace(1, 0); idle(NB + 2); sweep();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule